// File: doc/BRIEF.md
# Console Memory Map Address Decoder

This block sits between the CPU of an 8-bit handheld console and everything that CPU can address on its 16-bit bus. Each cycle it classifies the bus address into a region. It then does one of three things with the access. It sends it to an external port (cartridge ROM, the bank controller, the I/O register file). It serves it from an internal array (two work-RAM banks and a small high RAM). Or it answers it as an unpopulated stub.

Reads are one-cycle: the request is presented in cycle N, and the byte together with a valid flag appears in cycle N+1. External ports are strobed combinationally in cycle N, and their response is captured at the end of that cycle. Writes into the ROM space never touch ROM. They leave the block as control writes on the bank-controller port.

Top module: `mm_decoder`

## Requirements
- R1: While `rst_ni` is low, `cpu_rvalid_o` and `cpu_rdata_o` are 0. Every high-RAM byte reads 0 after a reset, including bytes written before it.
- R2: A read (`cpu_rd_i` high, `cpu_wr_i` low) in cycle N raises `cpu_rvalid_o` in cycle N+1 with the byte in `cpu_rdata_o`. When `cpu_rd_i` and `cpu_wr_i` are both high, only the write is performed and no valid follows.
- R3: A read at 0x0000–0x7FFF raises `rom_rd_o` in the same cycle with `rom_addr_o` = address[14:0]. Bit 14 set means the switchable window. The byte on `rom_rdata_i` is returned in the next cycle.
- R4: A write at 0x0000–0x7FFF raises `map_wr_o` with `map_addr_o` = address[14:0] and `map_data_o` = write data. It never raises `rom_rd_o` and does not change later ROM reads.
- R5: Reads at 0x8000–0xBFFF return 0. Writes there raise no external strobe.
- R6: Work-RAM bank 0 answers 0xC000–0xCFFF and its mirror 0xE000–0xEFFF. It is indexed by address[WRAM_AW-1:0].
- R7: Work-RAM bank 1 answers 0xD000–0xDFFF and 0xF000–0xFDFF. It is indexed by address[WRAM_AW-1:0].
- R8: Reads at 0xFE00–0xFEFF return 0. Writes there are ignored and raise no strobe.
- R9: Accesses at 0xFF00–0xFF7F raise `io_rd_o` or `io_wr_o` with `io_addr_o` = address[6:0] and `io_ie_o` low. A read returns `io_rdata_i` in the next cycle.
- R10: 0xFF80–0xFFFE is internal high RAM (127 bytes). Accesses there raise no I/O strobe.
- R11: Address 0xFFFF raises the I/O strobes with `io_ie_o` high and `io_addr_o` = 0.
- R12: At most one of `rom_rd_o`, `map_wr_o`, `io_rd_o`, `io_wr_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_addr_i | input | 16 | CPU bus address |
| cpu_wdata_i | input | 8 | CPU write data |
| cpu_rd_i | input | 1 | Read request |
| cpu_wr_i | input | 1 | Write request |
| cpu_rdata_o | output | 8 | Read data, one cycle after the request |
| cpu_rvalid_o | output | 1 | Read data valid |
| rom_rd_o | output | 1 | ROM read strobe |
| rom_addr_o | output | 15 | ROM offset; bit 14 selects the switchable window |
| rom_rdata_i | input | 8 | ROM read data, same cycle |
| map_wr_o | output | 1 | Bank-controller write strobe |
| map_addr_o | output | 15 | Bank-controller write offset |
| map_data_o | output | 8 | Bank-controller write data |
| io_rd_o | output | 1 | I/O register read strobe |
| io_wr_o | output | 1 | I/O register write strobe |
| io_addr_o | output | 7 | I/O register offset |
| io_ie_o | output | 1 | Access targets the interrupt-enable register |
| io_wdata_o | output | 8 | I/O write data |
| io_rdata_i | input | 8 | I/O read data, same cycle |

## Verification
The bench builds the decoder with `WRAM_AW` = 6, so each work-RAM bank is 64 bytes. Both banks are filled at start. Every random address then lands on a cell with known contents, and addresses differing only above bit 5 alias onto the same cell, as do the 0xE000 and 0xF000 mirrors.

The three region bases keep their default values. The full 127-byte high RAM and the 128-entry I/O window are therefore swept end to end, including the 0xFFFE/0xFFFF boundary. A mid-run reset checks that high RAM is cleared while the work RAM keeps its contents.

// File: rtl/mm_pkg.sv
package mm_pkg;
  typedef enum logic [3:0] {
    RG_NONE,
    RG_ROM_FIX,
    RG_ROM_BANK,
    RG_VRAM,
    RG_XRAM,
    RG_WRAM0,
    RG_WRAM1,
    RG_OAM,
    RG_IO,
    RG_HRAM,
    RG_IE
  } region_e;
endpackage

// File: rtl/mm_region_dec.sv
module mm_region_dec
  import mm_pkg::*;
#(
  parameter logic [15:0] OAM_BASE  = 16'hFE00,
  parameter logic [15:0] IO_BASE   = 16'hFF00,
  parameter logic [15:0] HRAM_BASE = 16'hFF80
) (
  input  logic [15:0] addr_i,
  output region_e     region_o
);
  always_comb begin
    case (addr_i[15:12])
      4'h0, 4'h1, 4'h2, 4'h3: region_o = RG_ROM_FIX;
      4'h4, 4'h5, 4'h6, 4'h7: region_o = RG_ROM_BANK;
      4'h8, 4'h9:             region_o = RG_VRAM;
      4'hA, 4'hB:             region_o = RG_XRAM;
      4'hC, 4'hE:             region_o = RG_WRAM0;
      4'hD:                   region_o = RG_WRAM1;
      default: begin
        // top nibble: mirror, stub, I/O, high RAM, IE
        if (addr_i < OAM_BASE)       region_o = RG_WRAM1;
        else if (addr_i < IO_BASE)   region_o = RG_OAM;
        else if (addr_i < HRAM_BASE) region_o = RG_IO;
        else if (addr_i != 16'hFFFF) region_o = RG_HRAM;
        else                         region_o = RG_IE;
      end
    endcase
  end
endmodule

// File: rtl/mm_ram.sv
module mm_ram #(
  parameter int unsigned DW    = 8,
  parameter int unsigned AW    = 8,
  parameter int unsigned DEPTH = 1 << AW,
  parameter bit          CLEAR = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] q;

  if (CLEAR) begin : g_clr
    logic [DW-1:0] mem [DEPTH];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < int'(DEPTH); i++) mem[i] <= '0;
      end else if (we_i) begin
        mem[addr_i] <= wdata_i;
      end
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   q <= '0;
      else if (re_i) q <= mem[addr_i];
    end
  end else begin : g_plain
    logic [DW-1:0] mem [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i) mem[addr_i] <= wdata_i;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   q <= '0;
      else if (re_i) q <= mem[addr_i];
    end
  end

  assign rdata_o = q;
endmodule

// File: rtl/mm_decoder.sv
module mm_decoder
  import mm_pkg::*;
#(
  parameter int unsigned WRAM_AW   = 12,
  parameter logic [15:0] OAM_BASE  = 16'hFE00,
  parameter logic [15:0] IO_BASE   = 16'hFF00,
  parameter logic [15:0] HRAM_BASE = 16'hFF80,
  localparam int unsigned IO_AW      = $clog2(32'(HRAM_BASE) - 32'(IO_BASE)),
  localparam int unsigned HRAM_DEPTH = 32'hFFFF - 32'(HRAM_BASE),
  localparam int unsigned HRAM_AW    = $clog2(HRAM_DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [15:0]      cpu_addr_i,
  input  logic [7:0]       cpu_wdata_i,
  input  logic             cpu_rd_i,
  input  logic             cpu_wr_i,
  output logic [7:0]       cpu_rdata_o,
  output logic             cpu_rvalid_o,
  output logic             rom_rd_o,
  output logic [14:0]      rom_addr_o,
  input  logic [7:0]       rom_rdata_i,
  output logic             map_wr_o,
  output logic [14:0]      map_addr_o,
  output logic [7:0]       map_data_o,
  output logic             io_rd_o,
  output logic             io_wr_o,
  output logic [IO_AW-1:0] io_addr_o,
  output logic             io_ie_o,
  output logic [7:0]       io_wdata_o,
  input  logic [7:0]       io_rdata_i
);
  localparam int unsigned NBANK = 2;

  region_e region;
  logic    rd_ok, is_rom, is_io;

  mm_region_dec #(
    .OAM_BASE (OAM_BASE),
    .IO_BASE  (IO_BASE),
    .HRAM_BASE(HRAM_BASE)
  ) u_dec (
    .addr_i  (cpu_addr_i),
    .region_o(region)
  );

  // write wins over a simultaneous read
  assign rd_ok  = cpu_rd_i & ~cpu_wr_i;
  assign is_rom = (region == RG_ROM_FIX) || (region == RG_ROM_BANK);
  assign is_io  = (region == RG_IO) || (region == RG_IE);

  // external ports
  assign rom_rd_o   = rd_ok & is_rom;
  assign rom_addr_o = cpu_addr_i[14:0];
  assign map_wr_o   = cpu_wr_i & is_rom;
  assign map_addr_o = cpu_addr_i[14:0];
  assign map_data_o = cpu_wdata_i;
  assign io_rd_o    = rd_ok & is_io;
  assign io_wr_o    = cpu_wr_i & is_io;
  assign io_addr_o  = (region == RG_IO) ? cpu_addr_i[IO_AW-1:0] : '0;
  assign io_ie_o    = (region == RG_IE) & (cpu_rd_i | cpu_wr_i);
  assign io_wdata_o = cpu_wdata_i;

  // work RAM banks
  logic [NBANK-1:0]      wram_hit;
  logic [NBANK-1:0][7:0] wram_q;

  assign wram_hit = {region == RG_WRAM1, region == RG_WRAM0};

  for (genvar b = 0; b < NBANK; b++) begin : g_wram
    mm_ram #(
      .DW   (8),
      .AW   (WRAM_AW),
      .DEPTH(1 << WRAM_AW),
      .CLEAR(1'b0)
    ) u_ram (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (cpu_wr_i & wram_hit[b]),
      .re_i   (rd_ok & wram_hit[b]),
      .addr_i (cpu_addr_i[WRAM_AW-1:0]),
      .wdata_i(cpu_wdata_i),
      .rdata_o(wram_q[b])
    );
  end

  // high RAM, cleared on reset
  logic [7:0] hram_q;
  logic       hram_hit;

  assign hram_hit = (region == RG_HRAM);

  mm_ram #(
    .DW   (8),
    .AW   (HRAM_AW),
    .DEPTH(HRAM_DEPTH),
    .CLEAR(1'b1)
  ) u_hram (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cpu_wr_i & hram_hit),
    .re_i   (rd_ok & hram_hit),
    .addr_i (cpu_addr_i[HRAM_AW-1:0]),
    .wdata_i(cpu_wdata_i),
    .rdata_o(hram_q)
  );

  // read return stage
  region_e    sel_q;
  logic [7:0] ext_q;
  logic       rvalid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q    <= RG_NONE;
      ext_q    <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_ok;
      if (rd_ok) begin
        sel_q <= region;
        if (is_rom)     ext_q <= rom_rdata_i;
        else if (is_io) ext_q <= io_rdata_i;
      end
    end
  end

  always_comb begin
    case (sel_q)
      RG_ROM_FIX, RG_ROM_BANK, RG_IO, RG_IE: cpu_rdata_o = ext_q;
      RG_WRAM0: cpu_rdata_o = wram_q[0];
      RG_WRAM1: cpu_rdata_o = wram_q[1];
      RG_HRAM:  cpu_rdata_o = hram_q;
      default:  cpu_rdata_o = 8'h00;
    endcase
  end

  assign cpu_rvalid_o = rvalid_q;
endmodule

// File: rtl/mm_decoder_chk.sv
module mm_decoder_chk #(
  parameter logic [15:0] HRAM_BASE = 16'hFF80
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] cpu_addr_i,
  input logic        cpu_rd_i,
  input logic        cpu_wr_i,
  input logic [7:0]  cpu_rdata_o,
  input logic        cpu_rvalid_o,
  input logic        rom_rd_o,
  input logic        map_wr_o,
  input logic        io_rd_o,
  input logic        io_wr_o,
  input logic        io_ie_o
);
  AST_RVALID_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_rvalid_o == $past(cpu_rd_i && !cpu_wr_i)); // R2

  AST_ROM_WR_MAPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_wr_i && !cpu_addr_i[15]) |-> (map_wr_o && !rom_rd_o)); // R4

  AST_STUB_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_rvalid_o && $past(cpu_addr_i[15:14] == 2'b10)) |-> (cpu_rdata_o == 8'h00)); // R5

  AST_OAM_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_rvalid_o && $past(cpu_addr_i[15:8] == 8'hFE)) |-> (cpu_rdata_o == 8'h00)); // R8

  AST_HRAM_NO_IO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_addr_i >= HRAM_BASE && cpu_addr_i != 16'hFFFF) |-> (!io_rd_o && !io_wr_o)); // R10

  AST_IE_TOP_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_ie_o |-> (cpu_addr_i == 16'hFFFF && (io_rd_o || io_wr_o))); // R11

  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({rom_rd_o, map_wr_o, io_rd_o, io_wr_o}) <= 1); // R12
endmodule

bind mm_decoder mm_decoder_chk #(.HRAM_BASE(HRAM_BASE)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cpu_addr_i  (cpu_addr_i),
  .cpu_rd_i    (cpu_rd_i),
  .cpu_wr_i    (cpu_wr_i),
  .cpu_rdata_o (cpu_rdata_o),
  .cpu_rvalid_o(cpu_rvalid_o),
  .rom_rd_o    (rom_rd_o),
  .map_wr_o    (map_wr_o),
  .io_rd_o     (io_rd_o),
  .io_wr_o     (io_wr_o),
  .io_ie_o     (io_ie_o)
);

// File: tb/mm_decoder_test.sv
module mm_decoder_test;
  localparam int WAW   = 6;
  localparam int WSIZE = 1 << WAW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [7:0]  rdata;
  logic        rvalid;
  logic        rom_rd, map_wr, io_rd, io_wr, io_ie;
  logic [14:0] rom_addr, map_addr;
  logic [7:0]  map_data, io_wdata, rom_rdata, io_rdata;
  logic [6:0]  io_addr;

  always #2 clk = ~clk;

  function automatic logic [7:0] rom_val(logic [14:0] a);
    return a[7:0] ^ {1'b0, a[14:8]};
  endfunction

  function automatic logic [7:0] io_val(logic ie, logic [6:0] off);
    return ie ? 8'hA5 : (8'h3C ^ {1'b1, off});
  endfunction

  assign rom_rdata = rom_val(rom_addr);
  assign io_rdata  = io_val(io_ie, io_addr);

  mm_decoder #(.WRAM_AW(WAW)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_addr_i(addr), .cpu_wdata_i(wdata), .cpu_rd_i(rd), .cpu_wr_i(wr),
    .cpu_rdata_o(rdata), .cpu_rvalid_o(rvalid),
    .rom_rd_o(rom_rd), .rom_addr_o(rom_addr), .rom_rdata_i(rom_rdata),
    .map_wr_o(map_wr), .map_addr_o(map_addr), .map_data_o(map_data),
    .io_rd_o(io_rd), .io_wr_o(io_wr), .io_addr_o(io_addr), .io_ie_o(io_ie),
    .io_wdata_o(io_wdata), .io_rdata_i(io_rdata)
  );

  int  checks = 0, fails = 0;
  bit  done = 1'b0;
  logic [7:0] w0 [WSIZE];
  logic [7:0] w1 [WSIZE];
  logic [7:0] hr [127];
  logic       exp_v = 1'b0;
  logic [7:0] exp_d = '0;
  string      exp_tag = "R2";

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(logic [15:0] a, logic w);
    if (a < 16'h8000) return w ? "R4" : "R3";
    if (a < 16'hC000) return "R5";
    if (a[15:12] == 4'hC || a[15:12] == 4'hE) return "R6";
    if (a < 16'hFE00) return "R7";
    if (a < 16'hFF00) return "R8";
    if (a < 16'hFF80) return "R9";
    if (a < 16'hFFFF) return "R10";
    return "R11";
  endfunction

  function automatic logic [7:0] model_rd(logic [15:0] a);
    if (a < 16'h8000) return rom_val(a[14:0]);
    if (a < 16'hC000) return 8'h00;
    if (a[15:12] == 4'hC || a[15:12] == 4'hE) return w0[int'(a[WAW-1:0])];
    if (a < 16'hFE00) return w1[int'(a[WAW-1:0])];
    if (a < 16'hFF00) return 8'h00;
    if (a < 16'hFF80) return io_val(1'b0, a[6:0]);
    if (a < 16'hFFFF) return hr[int'(a) - 'hFF80];
    return io_val(1'b1, 7'd0);
  endfunction

  task automatic model_wr(logic [15:0] a, logic [7:0] d);
    if (a[15:12] == 4'hC || a[15:12] == 4'hE) w0[int'(a[WAW-1:0])] = d;
    else if (a >= 16'hD000 && a < 16'hFE00 && a[15:12] != 4'hE) w1[int'(a[WAW-1:0])] = d;
    else if (a >= 16'hFF80 && a < 16'hFFFF) hr[int'(a) - 'hFF80] = d;
  endtask

  task automatic op(logic r, logic w, logic [15:0] a, logic [7:0] d);
    logic  is_rom, is_io, e_rrd, e_map, e_ird, e_iwr;
    string t;
    @(negedge clk);
    chk(rvalid == exp_v, "R2", "rvalid", int'(rvalid), int'(exp_v));
    if (exp_v) chk(rdata == exp_d, exp_tag, "rdata", int'(rdata), int'(exp_d));
    rd = r; wr = w; addr = a; wdata = d;
    #1;
    is_rom = (a < 16'h8000);
    is_io  = (a >= 16'hFF00 && a < 16'hFF80) || (a == 16'hFFFF);
    e_rrd = r && !w && is_rom;
    e_map = w && is_rom;
    e_ird = r && !w && is_io;
    e_iwr = w && is_io;
    t = tag_of(a, w);
    chk(rom_rd == e_rrd, t, "rom_rd", int'(rom_rd), int'(e_rrd));
    chk(map_wr == e_map, t, "map_wr", int'(map_wr), int'(e_map));
    chk(io_rd == e_ird, t, "io_rd", int'(io_rd), int'(e_ird));
    chk(io_wr == e_iwr, t, "io_wr", int'(io_wr), int'(e_iwr));
    if (e_rrd) chk(rom_addr == a[14:0], "R3", "rom_addr", int'(rom_addr), int'(a[14:0]));
    if (e_map) begin
      chk(map_addr == a[14:0], "R4", "map_addr", int'(map_addr), int'(a[14:0]));
      chk(map_data == d, "R4", "map_data", int'(map_data), int'(d));
    end
    if (e_ird || e_iwr) begin
      chk(io_ie == (a == 16'hFFFF), t, "io_ie", int'(io_ie), int'(a == 16'hFFFF));
      chk(io_addr == ((a == 16'hFFFF) ? 7'd0 : a[6:0]), t, "io_addr",
          int'(io_addr), int'((a == 16'hFFFF) ? 7'd0 : a[6:0]));
      if (e_iwr) chk(io_wdata == d, "R9", "io_wdata", int'(io_wdata), int'(d));
    end
    chk($countones({rom_rd, map_wr, io_rd, io_wr}) <= 1, "R12", "strobes",
        $countones({rom_rd, map_wr, io_rd, io_wr}), 1);
    exp_v = r && !w;
    if (exp_v) begin
      exp_d   = model_rd(a);
      exp_tag = t;
    end
    if (w) model_wr(a, d);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; rd = 1'b0; wr = 1'b0;
    #1;
    chk(rvalid == 1'b0, "R1", "rvalid in reset", int'(rvalid), 0);
    chk(rdata == 8'h00, "R1", "rdata in reset", int'(rdata), 0);
    for (int i = 0; i < 127; i++) hr[i] = 8'h00;
    exp_v = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R2 watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 127; i++) hr[i] = 8'h00;
    repeat (2) @(negedge clk);
    #1;
    chk(rvalid == 1'b0, "R1", "rvalid in reset", int'(rvalid), 0);
    chk(rdata == 8'h00, "R1", "rdata in reset", int'(rdata), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1, R10: high RAM cleared
    for (int i = 0; i < 127; i++) op(1, 0, 16'hFF80 + 16'(i), 8'h00);
    // R6, R7: fill both banks
    for (int i = 0; i < WSIZE; i++) op(0, 1, 16'hC000 + 16'(i), 8'(i * 3 + 1));
    for (int i = 0; i < WSIZE; i++) op(0, 1, 16'hD000 + 16'(i), 8'(i * 5 + 7));

    // R3: fixed and switchable ROM
    op(1, 0, 16'h0000, 0); op(1, 0, 16'h3FFF, 0); op(1, 0, 16'h4000, 0); op(1, 0, 16'h7FFF, 0);
    // R4: mapper writes, ROM unchanged afterwards
    op(0, 1, 16'h2000, 8'h05); op(0, 1, 16'h4123, 8'hFF); op(1, 0, 16'h2000, 0); op(1, 0, 16'h4123, 0);
    // R5: video and cartridge RAM stubs
    op(0, 1, 16'h8000, 8'h77); op(1, 0, 16'h8000, 0); op(0, 1, 16'hBFFF, 8'h11); op(1, 0, 16'hBFFF, 0);
    op(1, 0, 16'h9ABC, 0); op(1, 0, 16'hA123, 0);
    // R6: bank 0 and its mirror, aliasing above WRAM_AW
    op(0, 1, 16'hC005, 8'h9E); op(1, 0, 16'hE045, 0); op(1, 0, 16'hCFC5, 0);
    op(0, 1, 16'hEFFF, 8'h42); op(1, 0, 16'hC03F, 0);
    // R7: bank 1 and its mirror
    op(0, 1, 16'hD010, 8'h6B); op(1, 0, 16'hF010, 0); op(0, 1, 16'hFDFF, 8'hC3); op(1, 0, 16'hD03F, 0);
    op(1, 0, 16'hC010, 0);
    // R8: sprite attribute stub
    op(0, 1, 16'hFE00, 8'h33); op(1, 0, 16'hFE00, 0); op(0, 1, 16'hFEFF, 8'h44); op(1, 0, 16'hFEFF, 0);
    // R9: I/O window
    op(1, 0, 16'hFF00, 0); op(1, 0, 16'hFF7F, 0); op(0, 1, 16'hFF42, 8'h5A); op(1, 0, 16'hFF42, 0);
    // R10, R11: high RAM edges and IE
    op(0, 1, 16'hFF80, 8'hA1); op(0, 1, 16'hFFFE, 8'hB2); op(1, 0, 16'hFF80, 0); op(1, 0, 16'hFFFE, 0);
    op(1, 0, 16'hFFFF, 0); op(0, 1, 16'hFFFF, 8'h1F);
    // R2: simultaneous read and write performs only the write
    op(1, 1, 16'hFF90, 8'hD4); op(1, 0, 16'hFF90, 0); op(1, 1, 16'h1000, 8'h01); op(0, 0, 16'h0000, 0);
    op(1, 0, 16'hC001, 0); op(1, 0, 16'hD001, 0); op(1, 0, 16'hFF81, 0);

    // R1: reset clears high RAM, work RAM keeps contents
    op(0, 1, 16'hFFA0, 8'hEE);
    op(0, 0, 16'h0000, 0);
    do_reset();
    op(1, 0, 16'hFFA0, 0); op(1, 0, 16'hFF80, 0); op(1, 0, 16'hC005, 0);

    // mixed traffic
    for (int n = 0; n < 4000; n++) begin
      logic [15:0] a;
      logic [1:0]  k;
      a = 16'($urandom);
      if ($urandom % 2 == 0) a[15:14] = 2'b11;
      if ($urandom % 4 == 0) a[15:8] = 8'hFF;
      k = 2'($urandom);
      op(k == 2'd1 || k == 2'd3, k[1], a, 8'($urandom));
    end
    op(0, 0, 16'h0000, 0);
    op(0, 0, 16'h0000, 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule